// File: doc/BRIEF.md
# Base-Address Pretranslation Predictor Table

This block sits beside the address-generation stage of a load/store pipe and lets most data accesses bypass a fully associative translation buffer. It is keyed by the base register operand of a base-plus-displacement access. In the cycle before the effective address is computed, the base operand selects a set and the block takes a copy of its entries. In the next cycle the computed effective address arrives and a comparator checks whether the page predicted for that base matches the real page. On a match the cached physical frame and attribute bits go straight to the cache tag compare. Otherwise the block raises a request to the external translation buffer.

After a miss, the next translation response is written into the table for the base that missed, so each entry always holds the most recent page seen for its base. When the translation buffer evicts or shoots down a page, it sends that virtual page number to the block. The block then drops every entry predicting that page, so the table never holds a translation the buffer no longer has. Sets are direct-mapped or two-way with a least-recently-used victim.

Top module: `ptp_table`

## Requirements
- R1: After reset every entry is invalid: while `eaValid` is low, `pretransHit` and `tlbReq` are 0, and the first access to any base misses.
- R2: A lookup presents `baseAddr` with `lookupValid` in cycle T. The effective address arrives with `eaValid` in cycle T+1, and `pretransHit`, `tlbReq`, `xlatePa` and `xlateAttr` are valid in that same cycle T+1.
- R3: A prediction hits only when a valid entry's full 64-bit base tag equals the base of cycle T and its stored page number equals `effAddr[63:12]`. Offset bits are ignored. On a hit, `xlatePa` is `{stored frame, effAddr[11:0]}` and `xlateAttr` is the stored attribute. Both are 0 when there is no hit.
- R4: `tlbReq` is 1 exactly in a cycle with `eaValid` high and `pretransHit` low. Both outputs are 0 when `eaValid` is low.
- R5: After a tag miss, the next `tlbRespValid` allocates the missing base with the response page, frame and attribute, and the following access with that base and page hits.
- R6: A tag hit with the wrong page requests translation. The response then overwrites that same entry, so the new page hits and the old page misses.
- R7: With two ways, the victim for a tag miss is the least recently used way of the set. Both a hit and a refill make their way the most recently used.
- R8: The set index is `baseAddr[6:3]`. Two bases in one set coexist, and a third evicts one of them.
- R9: An invalidation (`invValid`, `invVpn`) removes every entry whose predicted page equals `invVpn`, including several bases that share it.
- R10: A refill whose page equals an invalidation in the same cycle leaves no valid entry.
- R11: An invalidation of the predicted page in cycle T or in cycle T+1 of a lookup suppresses the hit in cycle T+1.
- R12: An effective address with no lookup in the cycle before misses and allocates nothing. A response that follows it writes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Base operand present this cycle |
| baseAddr | input | 64 | Base register value |
| eaValid | input | 1 | Effective address present this cycle |
| effAddr | input | 64 | Computed effective virtual address |
| pretransHit | output | 1 | Prediction correct, use cached translation |
| xlatePa | output | 48 | Physical address on a hit, else 0 |
| xlateAttr | output | 16 | Permission and attribute bits on a hit, else 0 |
| tlbReq | output | 1 | Translation buffer lookup required |
| tlbRespValid | input | 1 | Translation response strobe |
| tlbRespVpn | input | 52 | Virtual page number of the response |
| tlbRespPfn | input | 36 | Physical frame number of the response |
| tlbRespAttr | input | 16 | Attribute bits of the response |
| invValid | input | 1 | Page invalidation strobe |
| invVpn | input | 52 | Virtual page to invalidate |

## Verification
Directed sequences cover several access patterns, each separating one cause of a miss from another:
- the first touch of a base;
- the same base repeated on one page with different offsets (only the offset merge may change);
- the same base moving to a new page (overwrite in place rather than allocation);
- three bases folded into one set (which way the LRU victim picks).

Shared-page bases followed by an invalidation show whether all matching entries are cleared. Invalidations placed in the lookup cycle, in the use cycle and together with a refill show that no stale translation is ever used. A random mix then runs over sixteen bases spread across four sets, with small and page-crossing displacements, occasional invalidations and killed refills, against a bench model of the table.

// File: rtl/ptp_pkg.sv
package ptp_pkg;

  // strobes handed from control to datapath each cycle
  typedef struct packed {
    logic capture;   // take a snapshot of the set selected by the base
    logic fill;      // write the pending entry from the response
    logic fillKill;  // response page is invalidated in the same cycle
  } ptpStrobe_t;

endpackage

// File: rtl/ptp_datapath.sv
module ptp_datapath
  import ptp_pkg::*;
#(
  parameter int ENTRIES    = 32,
  parameter int WAYS       = 2,
  parameter int VA_W       = 64,
  parameter int PA_W       = 48,
  parameter int ATTR_W     = 16,
  parameter int OFF_W      = 12,
  parameter int BASE_SHIFT = 3,
  localparam int SETS      = ENTRIES / WAYS,
  localparam int IDX_W     = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int VPN_W     = VA_W - OFF_W,
  localparam int PFN_W     = PA_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ptpStrobe_t        strobe,
  input  logic [VA_W-1:0]   baseAddr,
  input  logic [VA_W-1:0]   effAddr,
  input  logic              invValid,
  input  logic [VPN_W-1:0]  invVpn,
  input  logic [IDX_W-1:0]  fillSet,
  input  logic [WAY_W-1:0]  fillWay,
  input  logic [VA_W-1:0]   fillBase,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [PFN_W-1:0]  fillPfn,
  input  logic [ATTR_W-1:0] fillAttr,
  output logic              snapLive,
  output logic [IDX_W-1:0]  snapSet,
  output logic [VA_W-1:0]   snapBase,
  output logic              tagHitAny,
  output logic [WAY_W-1:0]  tagHitWay,
  output logic              pageHitAny,
  output logic [WAY_W-1:0]  pageHitWay,
  output logic [PA_W-1:0]   hitPa,
  output logic [ATTR_W-1:0] hitAttr
);

  // table storage
  logic [SETS-1:0][WAYS-1:0] entValid;
  logic [VA_W-1:0]   tagMem  [SETS][WAYS];
  logic [VPN_W-1:0]  vpnMem  [SETS][WAYS];
  logic [PFN_W-1:0]  pfnMem  [SETS][WAYS];
  logic [ATTR_W-1:0] attrMem [SETS][WAYS];

  // snapshot taken in the base cycle
  logic [WAYS-1:0]   snapTagHit;
  logic [VPN_W-1:0]  snapVpn  [WAYS];
  logic [PFN_W-1:0]  snapPfn  [WAYS];
  logic [ATTR_W-1:0] snapAttr [WAYS];

  logic [IDX_W-1:0]  rdSet;
  logic [WAYS-1:0]   pageHitW;
  logic [VPN_W-1:0]  effVpn;

  assign rdSet  = baseAddr[BASE_SHIFT +: IDX_W];
  assign effVpn = effAddr[VA_W-1:OFF_W];

  // valid bits: invalidation sweep, then refill (kill forces invalid)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
    end else begin
      if (invValid) begin
        for (int s = 0; s < SETS; s++) begin
          for (int w = 0; w < WAYS; w++) begin
            if (vpnMem[s][w] == invVpn) entValid[s][w] <= 1'b0;
          end
        end
      end
      if (strobe.fill) entValid[fillSet][fillWay] <= !strobe.fillKill;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fill) begin
      tagMem[fillSet][fillWay]  <= fillBase;
      vpnMem[fillSet][fillWay]  <= fillVpn;
      pfnMem[fillSet][fillWay]  <= fillPfn;
      attrMem[fillSet][fillWay] <= fillAttr;
    end
  end

  // snapshot: tag compare done in the base cycle, invalidations folded in
  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapLive   <= 1'b0;
      snapTagHit <= '0;
    end else begin
      snapLive <= strobe.capture;
      for (int w = 0; w < WAYS; w++) begin
        snapTagHit[w] <= strobe.capture && entValid[rdSet][w] &&
                         (tagMem[rdSet][w] == baseAddr) &&
                         !(invValid && (vpnMem[rdSet][w] == invVpn));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.capture) begin
      snapSet  <= rdSet;
      snapBase <= baseAddr;
      for (int w = 0; w < WAYS; w++) begin
        snapVpn[w]  <= vpnMem[rdSet][w];
        snapPfn[w]  <= pfnMem[rdSet][w];
        snapAttr[w] <= attrMem[rdSet][w];
      end
    end
  end

  // use cycle: page compare against the computed effective address
  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign pageHitW[w] = snapTagHit[w] && (snapVpn[w] == effVpn) &&
                           !(invValid && (snapVpn[w] == invVpn));
    end
  endgenerate

  always_comb begin
    tagHitAny  = 1'b0;
    tagHitWay  = '0;
    pageHitAny = 1'b0;
    pageHitWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (snapTagHit[w]) begin
        tagHitAny = 1'b1;
        tagHitWay = WAY_W'(w);
      end
      if (pageHitW[w]) begin
        pageHitAny = 1'b1;
        pageHitWay = WAY_W'(w);
      end
    end
  end

  assign hitPa   = {snapPfn[pageHitWay], effAddr[OFF_W-1:0]};
  assign hitAttr = snapAttr[pageHitWay];

endmodule

// File: rtl/ptp_ctrl.sv
module ptp_ctrl
  import ptp_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int WAYS    = 2,
  parameter int VA_W    = 64,
  parameter int OFF_W   = 12,
  localparam int SETS   = ENTRIES / WAYS,
  localparam int IDX_W  = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int VPN_W  = VA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic             eaValid,
  input  logic             tlbRespValid,
  input  logic [VPN_W-1:0] tlbRespVpn,
  input  logic             invValid,
  input  logic [VPN_W-1:0] invVpn,
  input  logic             snapLive,
  input  logic [IDX_W-1:0] snapSet,
  input  logic [VA_W-1:0]  snapBase,
  input  logic             tagHitAny,
  input  logic [WAY_W-1:0] tagHitWay,
  input  logic             pageHitAny,
  input  logic [WAY_W-1:0] pageHitWay,
  output ptpStrobe_t       strobe,
  output logic             pretransHit,
  output logic             tlbReq,
  output logic [IDX_W-1:0] fillSet,
  output logic [WAY_W-1:0] fillWay,
  output logic [VA_W-1:0]  fillBase
);

  logic             pendValid;
  logic [IDX_W-1:0] pendSet;
  logic [WAY_W-1:0] pendWay;
  logic [VA_W-1:0]  pendBase;
  logic [WAY_W-1:0] victimWay;
  logic             allocate;

  assign pretransHit = eaValid && pageHitAny;
  assign tlbReq      = eaValid && !pageHitAny;
  assign allocate    = tlbReq && snapLive;

  always_comb begin
    strobe          = '0;
    strobe.capture  = lookupValid;
    strobe.fill     = tlbRespValid && pendValid;
    strobe.fillKill = invValid && (invVpn == tlbRespVpn);
  end

  assign fillSet  = pendSet;
  assign fillWay  = pendWay;
  assign fillBase = pendBase;

  // one outstanding refill; a newer miss replaces an older one
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
    end else begin
      if (strobe.fill) pendValid <= 1'b0;
      if (allocate)    pendValid <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (allocate) begin
      pendSet  <= snapSet;
      pendBase <= snapBase;
      pendWay  <= tagHitAny ? tagHitWay : victimWay;
    end
  end

  generate
    if (WAYS == 2) begin : g_lru
      logic [SETS-1:0] lruWay;  // way to evict next
      assign victimWay = lruWay[snapSet];
      always_ff @(posedge clk) begin
        if (!rstN) begin
          lruWay <= '0;
        end else begin
          if (pretransHit) lruWay[snapSet] <= ~pageHitWay[0];
          if (strobe.fill) lruWay[pendSet] <= ~pendWay[0];
        end
      end
    end else begin : g_direct
      assign victimWay = '0;
    end
  endgenerate

endmodule

// File: rtl/ptp_table.sv
module ptp_table
  import ptp_pkg::*;
#(
  parameter int ENTRIES    = 32,
  parameter int WAYS       = 2,
  parameter int VA_W       = 64,
  parameter int PA_W       = 48,
  parameter int ATTR_W     = 16,
  parameter int OFF_W      = 12,
  parameter int BASE_SHIFT = 3,
  localparam int SETS      = ENTRIES / WAYS,
  localparam int IDX_W     = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int VPN_W     = VA_W - OFF_W,
  localparam int PFN_W     = PA_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [VA_W-1:0]   baseAddr,
  input  logic              eaValid,
  input  logic [VA_W-1:0]   effAddr,
  output logic              pretransHit,
  output logic [PA_W-1:0]   xlatePa,
  output logic [ATTR_W-1:0] xlateAttr,
  output logic              tlbReq,
  input  logic              tlbRespValid,
  input  logic [VPN_W-1:0]  tlbRespVpn,
  input  logic [PFN_W-1:0]  tlbRespPfn,
  input  logic [ATTR_W-1:0] tlbRespAttr,
  input  logic              invValid,
  input  logic [VPN_W-1:0]  invVpn
);

  ptpStrobe_t        strobe;
  logic              snapLive, tagHitAny, pageHitAny;
  logic [IDX_W-1:0]  snapSet, fillSet;
  logic [VA_W-1:0]   snapBase, fillBase;
  logic [WAY_W-1:0]  tagHitWay, pageHitWay, fillWay;
  logic [PA_W-1:0]   hitPa;
  logic [ATTR_W-1:0] hitAttr;

  ptp_datapath #(
    .ENTRIES(ENTRIES), .WAYS(WAYS), .VA_W(VA_W), .PA_W(PA_W),
    .ATTR_W(ATTR_W), .OFF_W(OFF_W), .BASE_SHIFT(BASE_SHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .baseAddr(baseAddr), .effAddr(effAddr),
    .invValid(invValid), .invVpn(invVpn),
    .fillSet(fillSet), .fillWay(fillWay), .fillBase(fillBase),
    .fillVpn(tlbRespVpn), .fillPfn(tlbRespPfn), .fillAttr(tlbRespAttr),
    .snapLive(snapLive), .snapSet(snapSet), .snapBase(snapBase),
    .tagHitAny(tagHitAny), .tagHitWay(tagHitWay),
    .pageHitAny(pageHitAny), .pageHitWay(pageHitWay),
    .hitPa(hitPa), .hitAttr(hitAttr)
  );

  ptp_ctrl #(
    .ENTRIES(ENTRIES), .WAYS(WAYS), .VA_W(VA_W), .OFF_W(OFF_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .eaValid(eaValid),
    .tlbRespValid(tlbRespValid), .tlbRespVpn(tlbRespVpn),
    .invValid(invValid), .invVpn(invVpn),
    .snapLive(snapLive), .snapSet(snapSet), .snapBase(snapBase),
    .tagHitAny(tagHitAny), .tagHitWay(tagHitWay),
    .pageHitAny(pageHitAny), .pageHitWay(pageHitWay),
    .strobe(strobe), .pretransHit(pretransHit), .tlbReq(tlbReq),
    .fillSet(fillSet), .fillWay(fillWay), .fillBase(fillBase)
  );

  assign xlatePa   = pretransHit ? hitPa   : '0;
  assign xlateAttr = pretransHit ? hitAttr : '0;

endmodule

// File: rtl/ptp_checker.sv
module ptp_checker #(
  parameter int VA_W  = 64,
  parameter int OFF_W = 12,
  localparam int VPN_W = VA_W - OFF_W
) (
  input logic             clk,
  input logic             rstN,
  input logic             lookupValid,
  input logic             eaValid,
  input logic [VA_W-1:0]  effAddr,
  input logic             invValid,
  input logic [VPN_W-1:0] invVpn,
  input logic             pretransHit,
  input logic             tlbReq
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !eaValid |-> (!pretransHit && !tlbReq)); // R4

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    eaValid |-> ($countones({pretransHit, tlbReq}) == 1)); // R4

  AST_HIT_AFTER_LOOKUP: assert property (@(posedge clk) disable iff (!rstN)
    pretransHit |-> $past(lookupValid)); // R12

  AST_INV_USE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    pretransHit |-> !(invValid && (invVpn == effAddr[VA_W-1:OFF_W]))); // R11

  AST_INV_BASE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    pretransHit |-> !($past(invValid) && ($past(invVpn) == effAddr[VA_W-1:OFF_W]))); // R11

endmodule

bind ptp_table ptp_checker #(.VA_W(VA_W), .OFF_W(OFF_W)) u_ptp_checker (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .eaValid(eaValid),
  .effAddr(effAddr), .invValid(invValid), .invVpn(invVpn),
  .pretransHit(pretransHit), .tlbReq(tlbReq)
);

// File: tb/ptp_table_bench.sv
`timescale 1ns/1ps
module ptp_table_bench;
  localparam int SETS = 16;
  localparam int WAYS = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0;
  logic [63:0] baseAddr = '0;
  logic        eaValid = 1'b0;
  logic [63:0] effAddr = '0;
  logic        pretransHit;
  logic [47:0] xlatePa;
  logic [15:0] xlateAttr;
  logic        tlbReq;
  logic        tlbRespValid = 1'b0;
  logic [51:0] tlbRespVpn = '0;
  logic [35:0] tlbRespPfn = '0;
  logic [15:0] tlbRespAttr = '0;
  logic        invValid = 1'b0;
  logic [51:0] invVpn = '0;

  always #2.5 clk = ~clk;

  ptp_table u_ptp_table (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .baseAddr(baseAddr),
    .eaValid(eaValid), .effAddr(effAddr), .pretransHit(pretransHit),
    .xlatePa(xlatePa), .xlateAttr(xlateAttr), .tlbReq(tlbReq),
    .tlbRespValid(tlbRespValid), .tlbRespVpn(tlbRespVpn),
    .tlbRespPfn(tlbRespPfn), .tlbRespAttr(tlbRespAttr),
    .invValid(invValid), .invVpn(invVpn)
  );

  // reference model of the table
  bit          mV    [SETS][WAYS];
  logic [63:0] mTag  [SETS][WAYS];
  logic [51:0] mVpn  [SETS][WAYS];
  logic [35:0] mPfn  [SETS][WAYS];
  logic [15:0] mAttr [SETS][WAYS];
  bit          mLru  [SETS];
  bit          pV;
  logic [63:0] pBase;
  int          pSet, pWay;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  function automatic logic [35:0] pfnOf(input logic [51:0] v);
    return v[35:0] ^ 36'h5_A5A5_0F0F;
  endfunction
  function automatic logic [15:0] attrOf(input logic [51:0] v);
    return v[15:0] ^ 16'hC3C3;
  endfunction
  function automatic int setOf(input logic [63:0] b);
    return int'(b[6:3]);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelInv(input logic [51:0] v);
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        if (mVpn[s][w] == v) mV[s][w] = 1'b0;
  endtask

  // one access: base in cycle T, effective address in T+1
  task automatic access(input logic [63:0] base, input logic [63:0] ea,
                        input string req, input bit invL = 0, input bit invU = 0,
                        input logic [51:0] iv = '0);
    int  s;
    bit  thit [WAYS];
    bit  tAny, hit;
    int  tWay, hWay;
    @(negedge clk);
    lookupValid = 1'b1; baseAddr = base; invValid = invL; invVpn = iv;
    if (invL) modelInv(iv);
    s = setOf(base);
    tAny = 0; tWay = 0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      thit[w] = mV[s][w] && (mTag[s][w] == base);
      if (thit[w]) begin tAny = 1; tWay = w; end
    end
    @(negedge clk);
    lookupValid = 1'b0; eaValid = 1'b1; effAddr = ea; invValid = invU; invVpn = iv;
    hit = 0; hWay = 0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (thit[w] && mVpn[s][w] == ea[63:12] && !(invU && mVpn[s][w] == iv)) begin
        hit = 1; hWay = w;
      end
    end
    #1;
    chk(pretransHit == hit, req, 64'(pretransHit), 64'(hit));
    chk(tlbReq == !hit, {req, " R4"}, 64'(tlbReq), 64'(!hit));
    if (hit) begin
      chk(xlatePa == {mPfn[s][hWay], ea[11:0]}, {req, " R3"}, 64'(xlatePa),
          64'({mPfn[s][hWay], ea[11:0]}));
      chk(xlateAttr == mAttr[s][hWay], {req, " R3"}, 64'(xlateAttr), 64'(mAttr[s][hWay]));
      mLru[s] = (hWay == 0);
    end else begin
      chk(xlatePa == 48'h0 && xlateAttr == 16'h0, {req, " R3"},
          64'({xlatePa, xlateAttr}), 64'h0);
      pV = 1; pBase = base; pSet = s; pWay = tAny ? tWay : int'(mLru[s]);
    end
    if (invU) modelInv(iv);
    @(negedge clk);
    eaValid = 1'b0; invValid = 1'b0;
  endtask

  task automatic respond(input logic [51:0] v, input bit kill = 0);
    @(negedge clk);
    tlbRespValid = 1'b1; tlbRespVpn = v; tlbRespPfn = pfnOf(v);
    tlbRespAttr = attrOf(v); invValid = kill; invVpn = v;
    if (pV) begin
      mV[pSet][pWay] = 1'b1; mTag[pSet][pWay] = pBase; mVpn[pSet][pWay] = v;
      mPfn[pSet][pWay] = pfnOf(v); mAttr[pSet][pWay] = attrOf(v);
      mLru[pSet] = (pWay == 0);
      pV = 0;
    end
    if (kill) modelInv(v);
    @(negedge clk);
    tlbRespValid = 1'b0; invValid = 1'b0;
  endtask

  task automatic invalidate(input logic [51:0] v);
    @(negedge clk);
    invValid = 1'b1; invVpn = v;
    modelInv(v);
    @(negedge clk);
    invValid = 1'b0;
  endtask

  task automatic missFill(input logic [63:0] base, input logic [63:0] ea, input string req);
    access(base, ea, req);
    if (pV) respond(ea[63:12]);
  endtask

  initial begin : watchdog
    #(5.0 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [63:0] a, b, c, d, e, f, g, pg;
    for (int s = 0; s < SETS; s++) begin
      mLru[s] = 0;
      for (int w = 0; w < WAYS; w++) begin
        mV[s][w] = 0; mTag[s][w] = '0; mVpn[s][w] = '0; mPfn[s][w] = '0; mAttr[s][w] = '0;
      end
    end
    pV = 0; pBase = '0; pSet = 0; pWay = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk(pretransHit == 1'b0 && tlbReq == 1'b0, "R1 idle after reset",
        64'({pretransHit, tlbReq}), 64'h0);

    a = 64'h0000_7ff0_0000_0010;
    access(a, a + 64'h8, "R1 first touch misses");
    respond(64'h0000_7ff0_0000_0);
    access(a, a + 64'h40, "R5 R2 refilled base hits");
    access(a, a + 64'hF00, "R3 offset ignored in compare");

    access(a, a + 64'h2000, "R6 tag hit wrong page");
    respond(64'h0000_7ff0_0000_2);
    access(a, a + 64'h2008, "R6 new page hits");
    access(a, a + 64'h10, "R6 old page now misses");
    respond(64'h0000_7ff0_0000_0);

    b = a + 64'h80; c = a + 64'h100;
    missFill(b, b, "R8 second base same set");
    access(a, a, "R8 first base still resident");
    access(b, b, "R8 second base resident");
    access(a, a + 64'h20, "R7 touch first base");
    missFill(c, c, "R8 third base misses");
    access(b, b, "R7 least recent base evicted");
    respond(b[63:12]);
    access(c, c, "R7 most recent base kept");

    pg = 64'h0000_5555_5000;
    d = 64'h0000_1000_0000_0008; e = 64'h0000_2000_0000_0028;
    missFill(d, pg + 64'h4, "R9 fill shared page base one");
    missFill(e, pg + 64'h8, "R9 fill shared page base two");
    access(d, pg + 64'h4, "R9 base one hits");
    access(e, pg + 64'h8, "R9 base two hits");
    invalidate(pg[63:12]);
    access(d, pg + 64'h4, "R9 base one cleared");
    access(e, pg + 64'h8, "R9 base two cleared");
    respond(pg[63:12]);

    f = 64'h0000_3000_0000_0030;
    access(f, f, "R10 miss before killed refill");
    respond(f[63:12], 1'b1);
    access(f, f, "R10 killed refill left nothing");
    respond(f[63:12]);
    access(f, f, "R11 normal hit");
    access(f, f, "R11 inv in base cycle", 1'b1, 1'b0, f[63:12]);
    respond(f[63:12]);
    access(f, f, "R11 inv in use cycle", 1'b0, 1'b1, f[63:12]);
    respond(f[63:12]);

    g = 64'h0000_4000_0000_0040;
    @(negedge clk);
    eaValid = 1'b1; effAddr = g;
    #1;
    chk(tlbReq == 1'b1 && pretransHit == 1'b0, "R12 no lookup means miss",
        64'({pretransHit, tlbReq}), 64'h1);
    @(negedge clk);
    eaValid = 1'b0;
    respond(g[63:12]);
    access(g, g, "R12 orphan response wrote nothing");
    respond(g[63:12]);

    for (int i = 0; i < 400; i++) begin
      logic [63:0] rb, re;
      logic [3:0]  k;
      k  = 4'($urandom_range(0, 15));
      rb = 64'h0000_7ff0_0000_0000 + 64'(k[1:0]) * 64'h8 + 64'(k[3:2]) * 64'h80;
      re = rb + 64'($urandom_range(0, 255));
      if ($urandom_range(0, 3) == 0) re = re + 64'($urandom_range(1, 2)) * 64'h1000;
      access(rb, re, "R5 R7 random access");
      if (pV) respond(re[63:12], $urandom_range(0, 7) == 0);
      if ($urandom_range(0, 9) == 0) invalidate(re[63:12]);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule